// File: doc/BRIEF.md
# Nibble I/O Port Unit for a 4-bit Microcontroller

This block is the port subsystem of a small 4-bit microcontroller core. The sequencer hands it an I/O command that is already decoded. With the command come a one-hot bit mask, the accumulator nibble, the low nibble of the data pointer and an 8-bit immediate operand. The unit drives seven latched output ports and samples four input ports. It returns a nibble for the accumulator and a skip flag that tells the sequencer to discard the next instruction.

Ports are numbered 0 to 8 and lettered A to I in that order. A command names its port in one of two ways. Either the port is fixed by the command, or it is taken from the data-pointer nibble. Indices 0 to 3 (A to D) can be read, and indices 2 to 8 (C to I) are outputs. Port I has only three pins. Bit set and bit clear work on the stored output latch, never on the pin. The immediate output command splits one byte across ports D and C.

Every command takes one clock. Results appear on the rising edge that samples the command.

Top module: `mcu_io_ports`

## Requirements
- R1: While `rst` is high at a rising edge, ports C to H go to 4'hF and `port_i` goes to 3'b111. `rd_data` goes to 0, and `skip` and `wr_err` go to 0.
- R2: Command 1 loads `pin_a` into `rd_data` at the next edge. Command 2 loads into `rd_data` the input selected by `dp_low`, where 0, 1, 2 and 3 select `pin_a`, `pin_b`, `pin_c` and `pin_d`.
- R3: An input access to any index from 4 to 15 sees the value 4'hF, as an undriven pin does.
- R4: Command 3 writes `acc_in` to port E. Command 4 writes `acc_in` to the output selected by `dp_low`, where indices 2 to 8 select C to I.
- R5: Command 5 writes `imm[7:4]` to port D and `imm[3:0]` to port C on the same edge.
- R6: Command 6 ORs `bit_mask` into the port E latch. Command 7 clears the `bit_mask` bits of the port E latch.
- R7: Command 8 sets and command 9 clears the `bit_mask` bits of the output latch selected by `dp_low`. All other bits of that latch keep their stored value.
- R8: `port_i` shows the low three bits of the last value written to port I.
- R9: Command 10 tests `pin_a` and command 11 tests the input selected by `dp_low`. `skip` is 1 after the edge exactly when (selected input & `bit_mask`) is nonzero.
- R10: After an edge that samples any command other than 10 or 11, `skip` is 0.
- R11: A write or bit command (4, 8 or 9) whose `dp_low` is 0, 1 or 9 to 15 changes no output port and raises `wr_err` for one cycle. `wr_err` is 0 after every other command.
- R12: Command 0 and the unused codes 12 to 15 change no port, and `rd_data` holds except under commands 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 4 | Decoded I/O command code (0 to 11 used) |
| bit_mask | input | 4 | One-hot bit operand |
| acc_in | input | 4 | Accumulator value |
| dp_low | input | 4 | Data-pointer low nibble, the indirect port index |
| imm | input | 8 | Immediate operand for the split output command |
| pin_a | input | 4 | Input port A |
| pin_b | input | 4 | Input port B |
| pin_c | input | 4 | Input port C |
| pin_d | input | 4 | Input port D |
| rd_data | output | 4 | Nibble returned to the accumulator |
| skip | output | 1 | Skip-next flag from bit tests |
| wr_err | output | 1 | One-cycle strobe for a write to an index with no output port |
| port_c | output | 4 | Output port C |
| port_d | output | 4 | Output port D |
| port_e | output | 4 | Output port E |
| port_f | output | 4 | Output port F |
| port_g | output | 4 | Output port G |
| port_h | output | 4 | Output port H |
| port_i | output | 3 | Output port I |

## Verification
Every result is registered once, so each one is due exactly one rising edge after its command is presented. This holds for output latches, `rd_data`, `skip` and `wr_err` alike. The bench applies each command on a falling edge and samples at the following falling edge, half a period after the edge that took the command. A strobe such as `wr_err` or `skip` is also sampled one cycle after that, to show that it has dropped. Read-modify-write results depend on earlier writes, so the table is ordered and its expected values follow the latch history.

// File: rtl/mcu_io_pkg.sv
package mcu_io_pkg;
    localparam int NIB       = 4;
    localparam int IDX_W     = 4;
    localparam int IMM_W     = 2 * NIB;
    localparam int IN_CNT    = 4;   // ports 0..3 readable
    localparam int OUT_FIRST = 2;   // first output index (C)
    localparam int OUT_CNT   = 7;   // C..I
    localparam int OUT_LAST  = OUT_FIRST + OUT_CNT - 1;
    localparam int I_W       = 3;   // pins on the last port
    localparam int CMD_W     = 4;

    localparam logic [IDX_W-1:0] IDX_A = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_E = IDX_W'(4);
    localparam logic [NIB-1:0]   IDLE  = {NIB{1'b1}};

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP    = 4'd0,
        CMD_IN_A   = 4'd1,
        CMD_IN_P   = 4'd2,
        CMD_OUT_E  = 4'd3,
        CMD_OUT_P  = 4'd4,
        CMD_OUT_CD = 4'd5,
        CMD_SET_E  = 4'd6,
        CMD_CLR_E  = 4'd7,
        CMD_SET_P  = 4'd8,
        CMD_CLR_P  = 4'd9,
        CMD_TST_A  = 4'd10,
        CMD_TST_P  = 4'd11
    } io_cmd_e;

    typedef enum logic [1:0] {
        WK_WHOLE,
        WK_SET,
        WK_CLR
    } wr_kind_e;

    function automatic logic is_out_idx(input logic [IDX_W-1:0] idx);
        return (int'(idx) >= OUT_FIRST) && (int'(idx) <= OUT_LAST);
    endfunction

    function automatic logic [NIB-1:0] apply_wr(input wr_kind_e k,
                                                input logic [NIB-1:0] old,
                                                input logic [NIB-1:0] data,
                                                input logic [NIB-1:0] mask);
        case (k)
            WK_SET:  return old | mask;
            WK_CLR:  return old & ~mask;
            default: return data;
        endcase
    endfunction
endpackage

// File: rtl/mcu_io_decode.sv
module mcu_io_decode
    import mcu_io_pkg::*;
(
    input  io_cmd_e                          cmd,
    input  logic [IDX_W-1:0]                 dp_low,
    input  logic [NIB-1:0]                   acc,
    input  logic [IMM_W-1:0]                 imm,
    output logic [OUT_CNT-1:0]               wr_en,
    output wr_kind_e                         wr_kind,
    output logic [OUT_CNT-1:0][NIB-1:0]      wr_data,
    output logic [IDX_W-1:0]                 rd_idx,
    output logic                             rd_load,
    output logic                             tst_en,
    output logic                             bad_wr
);
    logic             single;
    logic             split;
    logic [IDX_W-1:0] tgt;

    always_comb begin
        single  = 1'b0;
        split   = 1'b0;
        tgt     = IDX_E;
        wr_kind = WK_WHOLE;
        rd_idx  = IDX_A;
        rd_load = 1'b0;
        tst_en  = 1'b0;
        case (cmd)
            CMD_IN_A:   rd_load = 1'b1;
            CMD_IN_P:   begin rd_load = 1'b1; rd_idx = dp_low; end
            CMD_OUT_E:  single = 1'b1;
            CMD_OUT_P:  begin single = 1'b1; tgt = dp_low; end
            CMD_OUT_CD: split = 1'b1;
            CMD_SET_E:  begin single = 1'b1; wr_kind = WK_SET; end
            CMD_CLR_E:  begin single = 1'b1; wr_kind = WK_CLR; end
            CMD_SET_P:  begin single = 1'b1; wr_kind = WK_SET; tgt = dp_low; end
            CMD_CLR_P:  begin single = 1'b1; wr_kind = WK_CLR; tgt = dp_low; end
            CMD_TST_A:  tst_en = 1'b1;
            CMD_TST_P:  begin tst_en = 1'b1; rd_idx = dp_low; end
            default:    ;
        endcase
        bad_wr = single && !is_out_idx(tgt);
    end

    for (genvar g = 0; g < OUT_CNT; g++) begin : g_lane
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(OUT_FIRST + g);
        if (g < 2) begin : g_split
            // lane 0 = C takes low nibble, lane 1 = D takes high nibble
            assign wr_en[g]   = (single && tgt == MY_IDX) || split;
            assign wr_data[g] = split ? imm[g*NIB +: NIB] : acc;
        end else begin : g_plain
            assign wr_en[g]   = single && tgt == MY_IDX;
            assign wr_data[g] = acc;
        end
    end
endmodule

// File: rtl/mcu_io_in_sel.sv
module mcu_io_in_sel
    import mcu_io_pkg::*;
(
    input  logic [IDX_W-1:0]           idx,
    input  logic [IN_CNT-1:0][NIB-1:0] pins,
    output logic [NIB-1:0]             val
);
    always_comb begin
        val = IDLE;
        for (int i = 0; i < IN_CNT; i++) begin
            if (idx == IDX_W'(i)) val = pins[i];
        end
    end
endmodule

// File: rtl/mcu_io_out_bank.sv
module mcu_io_out_bank
    import mcu_io_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [OUT_CNT-1:0]          wr_en,
    input  wr_kind_e                    wr_kind,
    input  logic [OUT_CNT-1:0][NIB-1:0] wr_data,
    input  logic [NIB-1:0]              mask,
    output logic [OUT_CNT-1:0][NIB-1:0] latches
);
    for (genvar g = 0; g < OUT_CNT; g++) begin : g_latch
        always_ff @(posedge clk) begin
            if (rst)
                latches[g] <= IDLE;
            else if (wr_en[g])
                latches[g] <= apply_wr(wr_kind, latches[g], wr_data[g], mask);
        end
    end
endmodule

// File: rtl/mcu_io_ports.sv
module mcu_io_ports
    import mcu_io_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  cmd,
    input  logic [3:0]  bit_mask,
    input  logic [3:0]  acc_in,
    input  logic [3:0]  dp_low,
    input  logic [7:0]  imm,
    input  logic [3:0]  pin_a,
    input  logic [3:0]  pin_b,
    input  logic [3:0]  pin_c,
    input  logic [3:0]  pin_d,
    output logic [3:0]  rd_data,
    output logic        skip,
    output logic        wr_err,
    output logic [3:0]  port_c,
    output logic [3:0]  port_d,
    output logic [3:0]  port_e,
    output logic [3:0]  port_f,
    output logic [3:0]  port_g,
    output logic [3:0]  port_h,
    output logic [2:0]  port_i
);
    logic [OUT_CNT-1:0]          wr_en;
    wr_kind_e                    wr_kind;
    logic [OUT_CNT-1:0][NIB-1:0] wr_data;
    logic [OUT_CNT-1:0][NIB-1:0] latches;
    logic [IDX_W-1:0]            rd_idx;
    logic                        rd_load;
    logic                        tst_en;
    logic                        bad_wr;
    logic [NIB-1:0]              in_val;
    logic                        unused_i_msb;

    mcu_io_decode u_dec (
        .cmd     (io_cmd_e'(cmd)),
        .dp_low  (dp_low),
        .acc     (acc_in),
        .imm     (imm),
        .wr_en   (wr_en),
        .wr_kind (wr_kind),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_load (rd_load),
        .tst_en  (tst_en),
        .bad_wr  (bad_wr)
    );

    mcu_io_in_sel u_in (
        .idx  (rd_idx),
        .pins ({pin_d, pin_c, pin_b, pin_a}),
        .val  (in_val)
    );

    mcu_io_out_bank u_out (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_kind (wr_kind),
        .wr_data (wr_data),
        .mask    (bit_mask),
        .latches (latches)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            skip    <= 1'b0;
            wr_err  <= 1'b0;
        end else begin
            if (rd_load) rd_data <= in_val;
            skip   <= tst_en && ((in_val & bit_mask) != '0);
            wr_err <= bad_wr;
        end
    end

    assign port_c       = latches[0];
    assign port_d       = latches[1];
    assign port_e       = latches[2];
    assign port_f       = latches[3];
    assign port_g       = latches[4];
    assign port_h       = latches[5];
    assign port_i       = latches[OUT_CNT-1][I_W-1:0];
    assign unused_i_msb = latches[OUT_CNT-1][NIB-1];
endmodule

// File: rtl/mcu_io_ports_chk.sv
module mcu_io_ports_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] cmd,
    input logic [3:0] bit_mask,
    input logic [3:0] dp_low,
    input logic [7:0] imm,
    input logic [3:0] rd_data,
    input logic       skip,
    input logic       wr_err,
    input logic [3:0] port_c,
    input logic [3:0] port_d,
    input logic [3:0] port_e,
    input logic [2:0] port_i
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (port_c == 4'hF && port_d == 4'hF && port_e == 4'hF &&
                 port_i == 3'b111 && rd_data == 4'h0 && !skip && !wr_err));

    // R5
    split_write_chk: assert property (@(posedge clk) disable iff (rst)
        cmd == 4'd5 |=> (port_d == $past(imm[7:4]) && port_c == $past(imm[3:0])));

    // R6
    set_e_chk: assert property (@(posedge clk) disable iff (rst)
        cmd == 4'd6 |=> port_e == ($past(port_e) | $past(bit_mask)));

    // R6
    clr_e_chk: assert property (@(posedge clk) disable iff (rst)
        cmd == 4'd7 |=> port_e == ($past(port_e) & ~$past(bit_mask)));

    // R3
    idle_read_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'd2 && dp_low > 4'd3) |=> rd_data == 4'hF);

    // R10
    skip_only_test_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd != 4'd10 && cmd != 4'd11) |=> !skip);

    // R11
    bad_write_chk: assert property (@(posedge clk) disable iff (rst)
        ((cmd == 4'd4 || cmd == 4'd8 || cmd == 4'd9) && (dp_low < 4'd2 || dp_low > 4'd8))
        |=> (wr_err && $stable(port_c) && $stable(port_d) && $stable(port_e) && $stable(port_i)));

    // R12
    idle_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'd0 || cmd > 4'd11)
        |=> ($stable(port_c) && $stable(port_e) && $stable(rd_data) && !wr_err));
endmodule

bind mcu_io_ports mcu_io_ports_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .bit_mask (bit_mask),
    .dp_low   (dp_low),
    .imm      (imm),
    .rd_data  (rd_data),
    .skip     (skip),
    .wr_err   (wr_err),
    .port_c   (port_c),
    .port_d   (port_d),
    .port_e   (port_e),
    .port_i   (port_i)
);

// File: tb/mcu_io_ports_tb.sv
module mcu_io_ports_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] cmd, bit_mask, acc_in, dp_low;
    logic [7:0] imm;
    logic [3:0] pin_a, pin_b, pin_c, pin_d;
    logic [3:0] rd_data;
    logic       skip, wr_err;
    logic [3:0] port_c, port_d, port_e, port_f, port_g, port_h;
    logic [2:0] port_i;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    mcu_io_ports dut_i (
        .clk(clk), .rst(rst), .cmd(cmd), .bit_mask(bit_mask), .acc_in(acc_in),
        .dp_low(dp_low), .imm(imm), .pin_a(pin_a), .pin_b(pin_b), .pin_c(pin_c),
        .pin_d(pin_d), .rd_data(rd_data), .skip(skip), .wr_err(wr_err),
        .port_c(port_c), .port_d(port_d), .port_e(port_e), .port_f(port_f),
        .port_g(port_g), .port_h(port_h), .port_i(port_i)
    );

    // observed output: 0 rd_data, 1 skip, 2 wr_err, 3..9 ports C..I
    typedef struct packed {
        logic [3:0]  cmd;
        logic [3:0]  mask;
        logic [3:0]  acc;
        logic [3:0]  dp;
        logic [7:0]  imm;
        logic [15:0] pins;   // {d, c, b, a}
        logic [3:0]  obs;
        logic [3:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{4'd1,  4'h0, 4'h0, 4'h0, 8'h00, 16'h3A05, 4'd0, 4'h5, 4'd2},  // R2 in A
        '{4'd2,  4'h0, 4'h0, 4'h2, 8'h00, 16'h3A05, 4'd0, 4'hA, 4'd2},  // R2 in C
        '{4'd2,  4'h0, 4'h0, 4'h3, 8'h00, 16'h3A05, 4'd0, 4'h3, 4'd2},  // R2 in D
        '{4'd2,  4'h0, 4'h0, 4'h6, 8'h00, 16'h3A05, 4'd0, 4'hF, 4'd3},  // R3 idle
        '{4'd3,  4'h0, 4'h6, 4'h0, 8'h00, 16'h3A05, 4'd5, 4'h6, 4'd4},  // R4 E
        '{4'd4,  4'h0, 4'h9, 4'h5, 8'h00, 16'h3A05, 4'd6, 4'h9, 4'd4},  // R4 F
        '{4'd4,  4'h0, 4'hD, 4'h8, 8'h00, 16'h3A05, 4'd9, 4'h5, 4'd8},  // R8 I low bits
        '{4'd5,  4'h0, 4'h0, 4'h0, 8'h4C, 16'h3A05, 4'd3, 4'hC, 4'd5},  // R5 C
        '{4'd0,  4'h0, 4'h0, 4'h0, 8'h00, 16'h3A05, 4'd4, 4'h4, 4'd5},  // R5 D kept
        '{4'd7,  4'h4, 4'h0, 4'h0, 8'h00, 16'h3A05, 4'd5, 4'h2, 4'd6},  // R6 clr
        '{4'd6,  4'h8, 4'h0, 4'h0, 8'h00, 16'h3A05, 4'd5, 4'hA, 4'd6},  // R6 set
        '{4'd9,  4'h2, 4'h0, 4'h7, 8'h00, 16'h3A05, 4'd8, 4'hD, 4'd7},  // R7 clr H
        '{4'd8,  4'h8, 4'h0, 4'h3, 8'h00, 16'h3A05, 4'd4, 4'hC, 4'd7},  // R7 set D
        '{4'd10, 4'h4, 4'h0, 4'h0, 8'h00, 16'h3A05, 4'd1, 4'h1, 4'd9},  // R9 hit
        '{4'd10, 4'h2, 4'h0, 4'h0, 8'h00, 16'h3A05, 4'd1, 4'h0, 4'd9},  // R9 miss
        '{4'd11, 4'h1, 4'h0, 4'h1, 8'h00, 16'h3A05, 4'd1, 4'h0, 4'd9},  // R9 B
        '{4'd11, 4'h2, 4'h0, 4'hC, 8'h00, 16'h3A05, 4'd1, 4'h1, 4'd9},  // R9 idle idx
        '{4'd1,  4'h0, 4'h0, 4'h0, 8'h00, 16'h3A05, 4'd1, 4'h0, 4'd10}, // R10
        '{4'd4,  4'h0, 4'h0, 4'h1, 8'h00, 16'h3A05, 4'd2, 4'h1, 4'd11}, // R11 strobe
        '{4'd0,  4'h0, 4'h0, 4'h0, 8'h00, 16'h3A05, 4'd2, 4'h0, 4'd11}, // R11 drops
        '{4'd8,  4'h1, 4'h0, 4'hF, 8'h00, 16'h3A05, 4'd2, 4'h1, 4'd11}, // R11 strobe
        '{4'd14, 4'h0, 4'h0, 4'h0, 8'h00, 16'h3A05, 4'd0, 4'h5, 4'd12}  // R12 hold
    };

    function automatic logic [3:0] pick(input logic [3:0] sel);
        case (sel)
            4'd0:    return rd_data;
            4'd1:    return {3'b0, skip};
            4'd2:    return {3'b0, wr_err};
            4'd3:    return port_c;
            4'd4:    return port_d;
            4'd5:    return port_e;
            4'd6:    return port_f;
            4'd7:    return port_g;
            4'd8:    return port_h;
            default: return {1'b0, port_i};
        endcase
    endfunction

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] c, input logic [3:0] m, input logic [3:0] a,
                         input logic [3:0] d, input logic [7:0] im, input logic [15:0] p);
        cmd = c; bit_mask = m; acc_in = a; dp_low = d; imm = im;
        {pin_d, pin_c, pin_b, pin_a} = p;
        @(negedge clk);
    endtask

    initial begin
        #100000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive(4'd0, 4'h0, 4'h0, 4'h0, 8'h00, 16'hFFFF);
        drive(4'd0, 4'h0, 4'h0, 4'h0, 8'h00, 16'hFFFF);
        // R1 reset state
        check("R1 port_c", port_c, 4'hF);
        check("R1 port_h", port_h, 4'hF);
        check("R1 port_i", {1'b0, port_i}, 4'h7);
        check("R1 rd_data", rd_data, 4'h0);
        check("R1 skip", {3'b0, skip}, 4'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].cmd, VECS[i].mask, VECS[i].acc, VECS[i].dp, VECS[i].imm, VECS[i].pins);
            check($sformatf("R%0d vec%0d", VECS[i].req, i), pick(VECS[i].obs), VECS[i].exp);
        end

        // R11: bad writes left every output latch untouched
        check("R11 port_c", port_c, 4'hC);
        check("R11 port_d", port_d, 4'hC);
        check("R11 port_e", port_e, 4'hA);
        check("R11 port_f", port_f, 4'h9);
        check("R11 port_g", port_g, 4'hF);
        check("R11 port_h", port_h, 4'hD);
        check("R11 port_i", {1'b0, port_i}, 4'h5);

        // R4 indirect write to G, R7 bit clear on I
        drive(4'd4, 4'h0, 4'h0, 4'h6, 8'h00, 16'h3A05);
        check("R4 port_g", port_g, 4'h0);
        drive(4'd9, 4'h1, 4'h0, 4'h8, 8'h00, 16'h3A05);
        check("R7 port_i", {1'b0, port_i}, 4'h4);

        // R9 indirect test of pin_c, then R10 drop after NOP
        drive(4'd11, 4'h8, 4'h0, 4'h2, 8'h00, 16'h3A05);
        check("R9 skip C", {3'b0, skip}, 4'h1);
        drive(4'd0, 4'h0, 4'h0, 4'h0, 8'h00, 16'h3A05);
        check("R10 skip", {3'b0, skip}, 4'h0);

        // R1 mid-run reset
        rst = 1'b1;
        drive(4'd3, 4'h0, 4'h0, 4'h0, 8'h00, 16'h3A05);
        check("R1 port_e", port_e, 4'hF);
        check("R1 port_g", port_g, 4'hF);
        check("R1 rd_data", rd_data, 4'h0);
        rst = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule